// File: doc/BRIEF.md
# Write Push and Request Sequencer

This block sits on the write side of a master that talks to a memory port through a write-data FIFO and an address-request handshake. It takes one write job at a time, given as a start byte address, a length in words and a stream of data words. It then pushes the data into the FIFO and raises the matching address request in an order that guarantees the memory never needs data that has not yet arrived.

A multi-word job is always sent as one aligned burst of `BURST_WORDS` words. When the start address is not on a burst boundary, the block fills the burst with pad words before and after the payload. Pad words carry zero data and all byte enables low, so the memory discards them. A one-word job goes the other way round: the request comes first and the data is pushed after the acknowledge.

A static select input picks the FIFO flavour. For a shift-register FIFO the block holds off pushes while the almost-full flag is high. For a block-RAM FIFO, which has no usable almost-full flag, the block keeps a running byte count since the FIFO was last seen empty. When another full burst would not fit under `LIMIT_BYTES`, it waits for the empty flag before it finishes the job.

Top module: `wr_push_seq`

## Requirements
- R1: During and directly after reset, `job_ready` is high and `req`, `wr_push` and `job_done` are low.
- R2: For a job of two or more words, exactly `BURST_WORDS` pushes occur, all of them before `req` rises. No push occurs while `req` is high.
- R3: Inside a burst, push number k (counting from 0) carries the next stream word with all byte enables high when offset <= k < offset+len. Every other push carries zero data and all byte enables low. Here offset is the word index of the start address within its burst, that is address bits [log2(word bytes) +: log2(BURST_WORDS)].
- R4: A burst request presents `req_burst`=1 and `req_addr` equal to the job address with its low log2(BURST_WORDS × word bytes) bits cleared.
- R5: Once raised, `req` stays high until the cycle in which `ack` is sampled high. `req_addr` and `req_burst` stay stable while `req` is high.
- R6: A one-word job raises `req` with `req_burst`=0 and the exact job address, with no pushes outstanding. Its single push, with all byte enables high, occurs in a cycle after the acknowledge.
- R7: With `fifo_bram`=0, no push occurs in a cycle where `wr_afull` is high. With `fifo_bram`=1, `wr_afull` has no effect.
- R8: With `fifo_bram`=1, the bytes pushed since the FIFO was last empty never exceed `LIMIT_BYTES`. When the count since the last drain plus one burst would exceed `LIMIT_BYTES`, `job_done` is held back until `wr_empty` is high.
- R9: Without a drain, `job_done` pulses for one cycle in the cycle after the job's last handshake. For a burst that handshake is the acknowledge; for a one-word job it is the push.
- R10: Each job takes exactly `len` words from the input stream. Pad pushes do not assert `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_bram | input | 1 | 1: block-RAM FIFO rules, 0: shift-register FIFO rules (static) |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Block idle, job accepted when valid |
| job_addr | input | ADDR_W | Start byte address, word aligned |
| job_len | input | $clog2(BURST_WORDS+1) | Length in words, 1..BURST_WORDS-offset |
| job_done | output | 1 | One-cycle completion pulse |
| in_valid | input | 1 | Stream word available |
| in_ready | output | 1 | Stream word taken when valid |
| in_data | input | DATA_W | Stream word |
| wr_push | output | 1 | Write FIFO push |
| wr_data | output | DATA_W | Word pushed |
| wr_be | output | DATA_W/8 | Byte enables of the word pushed |
| req | output | 1 | Address request |
| req_burst | output | 1 | 1: burst of BURST_WORDS, 0: single word |
| req_addr | output | ADDR_W | Request byte address |
| ack | input | 1 | Request acknowledge |
| wr_afull | input | 1 | FIFO almost full |
| wr_empty | input | 1 | FIFO empty |

## Verification
Bursts are swept over every start offset inside a burst and every legal length. This separates leading padding, trailing padding and the no-padding case, and shows whether the payload shifts by the right number of beats. One-word jobs at each offset show the reversed request-then-push order and the exact, unaligned address. In shift-register mode the almost-full flag toggles on a fixed period and the input stream has gaps, so stalls from both sources overlap the burst fill. A block-RAM run mixes bursts and single words with almost-full held high. Its running byte count crosses the limit at different points, which tells an immediate completion apart from one that waits for a slowly draining FIFO.

// File: rtl/wr_push_seq.sv
module wr_push_seq #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int BURST_WORDS = 16,
  parameter int LIMIT_BYTES = 1024
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               fifo_bram,
  input  logic                               job_valid,
  output logic                               job_ready,
  input  logic [ADDR_W-1:0]                  job_addr,
  input  logic [$clog2(BURST_WORDS+1)-1:0]   job_len,
  output logic                               job_done,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [DATA_W-1:0]                  in_data,
  output logic                               wr_push,
  output logic [DATA_W-1:0]                  wr_data,
  output logic [DATA_W/8-1:0]                wr_be,
  output logic                               req,
  output logic                               req_burst,
  output logic [ADDR_W-1:0]                  req_addr,
  input  logic                               ack,
  input  logic                               wr_afull,
  input  logic                               wr_empty
);

  localparam int BE_W        = DATA_W / 8;
  localparam int LB          = $clog2(BE_W);
  localparam int OFF_W       = $clog2(BURST_WORDS);
  localparam int LEN_W       = $clog2(BURST_WORDS + 1);
  localparam int BURST_BYTES = BURST_WORDS * BE_W;
  localparam int WIN_W       = $clog2(LIMIT_BYTES + BURST_BYTES + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_BREQ, ST_SREQ, ST_SPUSH, ST_FIN, ST_DRAIN
  } st_t;

  st_t               state;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [OFF_W-1:0]  beat;
  logic [WIN_W-1:0]  win;

  logic [LEN_W:0] b_ext, lo, hi;
  logic           data_beat, room, beat_last, need_drain;

  assign b_ext     = (LEN_W + 1)'(beat);
  assign lo        = (LEN_W + 1)'(addr_q[LB +: OFF_W]);
  assign hi        = lo + (LEN_W + 1)'(len_q);
  assign data_beat = (state == ST_FILL) && (b_ext >= lo) && (b_ext < hi);
  assign beat_last = (beat == OFF_W'(BURST_WORDS - 1));
  assign room      = fifo_bram || !wr_afull;
  assign need_drain = fifo_bram && ((32'(win) + BURST_BYTES) > LIMIT_BYTES);

  assign in_ready  = room && (data_beat || state == ST_SPUSH);
  assign wr_push   = room && ((state == ST_FILL && (!data_beat || in_valid)) ||
                              (state == ST_SPUSH && in_valid));
  assign wr_be     = {BE_W{wr_push && in_ready}};
  assign wr_data   = (wr_push && in_ready) ? in_data : '0;

  assign job_ready = (state == ST_IDLE);
  assign req       = (state == ST_BREQ) || (state == ST_SREQ);
  assign req_burst = (state == ST_BREQ);
  assign req_addr  = (state == ST_BREQ) ? (addr_q & ~ADDR_W'(BURST_BYTES - 1)) : addr_q;
  assign job_done  = (state == ST_FIN && !need_drain) || (state == ST_DRAIN && wr_empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      len_q  <= '0;
      beat   <= '0;
      win    <= '0;
    end else begin
      if (!fifo_bram || (state == ST_DRAIN && wr_empty))
        win <= '0;
      else if (wr_push)
        win <= win + WIN_W'(BE_W);

      case (state)
        ST_IDLE:
          if (job_valid) begin
            addr_q <= job_addr;
            len_q  <= job_len;
            beat   <= '0;
            state  <= (job_len == LEN_W'(1)) ? ST_SREQ : ST_FILL;
          end
        ST_FILL:
          if (wr_push) begin
            if (beat_last) state <= ST_BREQ;
            else           beat  <= beat + 1'b1;
          end
        ST_BREQ:  if (ack)     state <= ST_FIN;
        ST_SREQ:  if (ack)     state <= ST_SPUSH;
        ST_SPUSH: if (wr_push) state <= ST_FIN;
        ST_FIN:   state <= need_drain ? ST_DRAIN : ST_IDLE;
        ST_DRAIN: if (wr_empty) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wr_push_seq_chk.sv
module wr_push_seq_chk #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int BURST_WORDS = 16,
  parameter int LIMIT_BYTES = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_bram,
  input logic              job_done,
  input logic              wr_push,
  input logic              req,
  input logic              req_burst,
  input logic [ADDR_W-1:0] req_addr,
  input logic              ack,
  input logic              wr_afull,
  input logic              wr_empty
);

  localparam int BE_W = DATA_W / 8;

  logic [31:0] pcnt;
  logic        owed;
  logic [31:0] cwin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      owed <= 1'b0;
      cwin <= '0;
    end else begin
      if (req && ack && req_burst)       pcnt <= '0;
      else if (wr_push && !owed)         pcnt <= pcnt + 1;
      if (req && ack && !req_burst)      owed <= 1'b1;
      else if (wr_push)                  owed <= 1'b0;
      if (wr_empty) cwin <= wr_push ? 32'(BE_W) : '0;
      else if (wr_push) cwin <= cwin + 32'(BE_W);
    end
  end

  p_burst_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) && req_burst |-> pcnt == 32'(BURST_WORDS));

  p_no_push_in_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !wr_push);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(req_addr) && $stable(req_burst));

  p_single_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req && !req_burst |-> pcnt == 0 && !owed);

  p_afull_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_bram && wr_afull |-> !wr_push);

  p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_bram |-> cwin <= 32'(LIMIT_BYTES));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done);

endmodule

bind wr_push_seq wr_push_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_WORDS(BURST_WORDS), .LIMIT_BYTES(LIMIT_BYTES)
) u_chk (.*);

// File: tb/wr_push_seq_tb.sv
module wr_push_seq_tb;
  localparam int DW = 16, AW = 12, BW = 4, LIM = 16, LW = 3;

  logic clk = 0, rst_n = 0, fifo_bram = 0;
  logic job_valid = 0, job_ready, job_done;
  logic [AW-1:0] job_addr = '0;
  logic [LW-1:0] job_len = '0;
  logic in_valid = 0, in_ready;
  logic [DW-1:0] in_data = '0;
  logic wr_push, req, req_burst, ack = 0, wr_afull = 0, wr_empty = 1;
  logic [DW-1:0] wr_data;
  logic [1:0] wr_be;
  logic [AW-1:0] req_addr;

  wr_push_seq #(.DATA_W(DW), .ADDR_W(AW), .BURST_WORDS(BW), .LIMIT_BYTES(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_bram(fifo_bram), .job_valid(job_valid), .job_ready(job_ready),
    .job_addr(job_addr), .job_len(job_len), .job_done(job_done), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .wr_push(wr_push), .wr_data(wr_data), .wr_be(wr_be),
    .req(req), .req_burst(req_burst), .req_addr(req_addr), .ack(ack), .wr_afull(wr_afull),
    .wr_empty(wr_empty));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // stimulus controls
  bit afull_en = 0, gap_en = 0, drain_en = 1, done_flag = 0;
  int feed_start = 0, feed_len = 0;
  logic [DW-1:0] base = '0;

  // monitor state
  int feed_idx = 0, np = 0, nreq = 0, ndone = 0;
  int pushed_total = 0, req_words = 0, drained = 0, ack_wait = 0;
  int ack_cyc = 0, rq_cyc = 0, done_cyc = 0;
  int afull_viol = 0, push_in_req = 0, unstable = 0, early_drop = 0;
  bit done_empty = 0, req_q = 0, ack_q = 0, burst_q = 0;
  logic [AW-1:0] rq_addr = '0, addr_q = '0;
  bit rq_burst = 0;
  logic [DW-1:0] log_d [0:1023];
  logic [1:0]    log_be[0:1023];
  int            log_c [0:1023];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // memory-side model
  always @(posedge clk) begin
    #1;
    if (req && !ack) begin
      if (ack_wait == 2) ack = 1;
      ack_wait++;
    end else begin
      ack = 0;
      ack_wait = 0;
    end
    if (drain_en && cyc[0] && drained < pushed_total && drained < req_words) drained++;
    wr_empty = (drained == pushed_total);
    wr_afull = afull_en && (cyc % 5 < 2);
    in_valid = (feed_idx - feed_start < feed_len) && !(gap_en && cyc % 3 == 0);
    in_data  = base + DW'(feed_idx - feed_start);
  end

  // port monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_valid && in_ready) feed_idx++;
      if (wr_push) begin
        log_d[np % 1024] = wr_data; log_be[np % 1024] = wr_be; log_c[np % 1024] = cyc;
        np++; pushed_total++;
        if (!fifo_bram && wr_afull) afull_viol++;
        if (req) push_in_req++;
      end
      if (req && !req_q) begin rq_addr = req_addr; rq_burst = req_burst; rq_cyc = cyc; nreq++; end
      if (req && req_q && (req_addr != addr_q || req_burst != burst_q)) unstable++;
      if (req_q && !req && !ack_q) early_drop++;
      if (req && ack) begin ack_cyc = cyc; req_words += req_burst ? BW : 1; end
      if (job_done) begin done_cyc = cyc; done_empty = wr_empty; ndone++; end
      req_q = req; ack_q = ack; addr_q = req_addr; burst_q = req_burst;
    end
  end

  int win_exp = 0, jobn = 0;

  task automatic run_job(input int addr, input int len);
    int ps, rs, ds, fs, off, ne, hs;
    bit isb, drain_exp;
    logic [1:0] ebe;
    logic [DW-1:0] ed;
    ps = np; rs = nreq; ds = ndone; fs = feed_idx;
    isb = (len > 1);
    off = (addr >> 1) & 3;
    base = DW'(16'hA000 + jobn * 16); jobn++;
    feed_start = feed_idx; feed_len = len;
    @(posedge clk); #1;
    job_addr = AW'(addr); job_len = LW'(len); job_valid = 1;
    @(posedge clk); #1;
    job_valid = 0;
    wait (ndone > ds);
    @(negedge clk);
    ne = isb ? BW : 1;
    chk(np - ps == ne, isb ? "R2 push count" : "R6 push count", np - ps, ne);
    for (int i = 0; i < ne; i++) begin
      ebe = (!isb || (i >= off && i < off + len)) ? 2'b11 : 2'b00;
      ed  = (ebe != 0) ? base + DW'(isb ? i - off : 0) : '0;
      chk(log_be[(ps+i)%1024] == ebe, "R3 byte enables", log_be[(ps+i)%1024], ebe);
      chk(log_d[(ps+i)%1024] == ed, "R3 push data", log_d[(ps+i)%1024], ed);
    end
    chk(nreq - rs == 1, "R5 one request", nreq - rs, 1);
    chk(rq_burst == isb, isb ? "R4 size" : "R6 size", rq_burst, isb);
    chk(rq_addr == AW'(isb ? (addr & ~7) : addr), isb ? "R4 address" : "R6 address", rq_addr,
        isb ? (addr & ~7) : addr);
    if (isb) chk(log_c[(ps+BW-1)%1024] < rq_cyc, "R2 push before request", log_c[(ps+BW-1)%1024], rq_cyc);
    else     chk(log_c[ps%1024] > ack_cyc, "R6 push after ack", log_c[ps%1024], ack_cyc + 1);
    chk(feed_idx - fs == len, "R10 words consumed", feed_idx - fs, len);
    hs = isb ? ack_cyc : log_c[ps%1024];
    win_exp += isb ? BW * 2 : 2;
    drain_exp = fifo_bram && (win_exp + BW * 2 > LIM);
    if (drain_exp) begin
      win_exp = 0;
      chk(done_empty, "R8 done waits for empty", done_empty, 1);
    end else begin
      chk(done_cyc == hs + 1, "R9 done timing", done_cyc, hs + 1);
    end
    chk(ndone - ds == 1, "R9 single pulse", ndone - ds, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(job_ready && !req && !wr_push && !job_done, "R1 reset state",
        {job_ready, req, wr_push, job_done}, 4'b1000);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(job_ready && !req && !wr_push && !job_done, "R1 after reset",
        {job_ready, req, wr_push, job_done}, 4'b1000);

    // shift-register mode: afull toggling, input gaps
    afull_en = 1; gap_en = 1;
    for (int o = 0; o < BW; o++)
      for (int l = 2; l <= BW - o; l++)
        run_job(12'h140 + o * 2, l);
    for (int o = 0; o < BW; o++) run_job(12'h208 + o * 2, 1);
    chk(afull_viol == 0, "R7 push during almost-full", afull_viol, 0);

    // block-RAM mode: afull held high and ignored, limit crossings
    wait (wr_empty); @(posedge clk); #1;
    afull_en = 0; wr_afull = 1; fifo_bram = 1; win_exp = 0;
    force wr_afull = 1'b1;
    run_job(12'h300, 4); run_job(12'h312, 3); run_job(12'h326, 1); run_job(12'h330, 2);
    for (int i = 0; i < 4; i++) run_job(12'h344 + i * 2, 1);
    run_job(12'h352, 2); run_job(12'h360, 4); run_job(12'h374, 2);
    release wr_afull;

    chk(push_in_req == 0, "R2 push while request", push_in_req, 0);
    chk(unstable == 0, "R5 request stability", unstable, 0);
    chk(early_drop == 0, "R5 request held to ack", early_drop, 0);
    done_flag = 1;
    summary();
  end

  always @(posedge clk) begin
    if (cyc == 150000 && !done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end
endmodule